// File: doc/BRIEF.md
# Power-Path Protection Sequencer

This block takes the digital side of a charger's power path. Comparators and sensors elsewhere report adapter presence, supply level, adapter overvoltage, input overcurrent, system overvoltage, junction temperature and whether the input-switch gate has charged. From these flags the block decides three things: whether the adapter counts as good, whether the input switches may conduct, and whether the buck converter may run and charge. It holds each of these decisions through the right recovery rule. Input overcurrent retries on its own after a timed pause. System overvoltage stays latched until the host clears it or the adapter is reconnected. Temperature follows separate hot and cool thresholds. A switch whose gate never reaches full drive is shut off after a deadline.

All timing is counted in pulses of a free-running millisecond tick, so the block runs from any system clock. Every output comes from registers inside the block. The converter enable is the AND of every release condition. Turning the converter back on hands control to the downstream soft-start logic.

Top module: `pwrpath_prot_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `adapter_ok`, `sw_en`, `conv_en` and `sysovp_stat` are 0 and `chg_dis` is 1.
- R2: `adapter_ok` equals `vcc_ok & adp_det & awake & !acovp`, sampled at one clock edge and presented after that edge.
- R3: While `acovp` is 1, `adapter_ok` and `sw_en` are 0 and `chg_dis` is 1. They come back once `acovp` is 0 with `adp_det` at 1.
- R4: With `ocp_en` = 1, a cycle with `in_ocp` = 1 clears `sw_en` at the next edge. The switch turns on again on the RETRY_MS-th `ms_tick` pulse after the last cycle in which `in_ocp` was high.
- R5: With `ocp_en` = 0, `in_ocp` has no effect on `sw_en`, `conv_en` or `chg_dis`.
- R6: When `in_ocp` asserts again during the retry pause, the pause starts over from zero ticks.
- R7: A cycle with `sys_ovp` = 1 clears `sw_en` and `conv_en` and sets `sysovp_stat` to 1. Both stay that way after `sys_ovp` falls, until R8 or R9 clears them.
- R8: A cycle with `ovp_clr` = 1 clears the latch, unless `sys_ovp` is 1 in that same cycle, in which case the latch stays set.
- R9: A 0-to-1 change of `adp_det` between two consecutive clock edges clears the latch.
- R10: While the overvoltage latch is set, the end of an overcurrent retry pause does not turn the switch on.
- R11: `therm_hot` = 1 clears `conv_en`. The converter stays off, even with both temperature flags at 0, until `therm_cool` = 1 with `therm_hot` = 0. Hot wins when both flags are 1.
- R12: Once `sw_en` has been 1 for GATE_MS `ms_tick` pulses, if `gate_good` is 0 on the last of those pulses, the switch is forced off. The force stays until `adp_det` goes to 0. If `gate_good` is 1 on that pulse, the switch stays on.
- R13: `conv_en` is 1 only while `sw_en` is 1 and no thermal hold is active. `chg_dis` is always the inverse of `conv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| vcc_ok | input | 1 | Supply above undervoltage lockout |
| adp_det | input | 1 | Adapter detect comparator |
| awake | input | 1 | Adapter-to-battery headroom present (not sleeping) |
| acovp | input | 1 | Adapter overvoltage comparator |
| in_ocp | input | 1 | Input overcurrent comparator |
| ocp_en | input | 1 | Configuration: input overcurrent protection enabled |
| sys_ovp | input | 1 | System overvoltage comparator |
| ovp_clr | input | 1 | Host write of zero to the overvoltage status |
| therm_hot | input | 1 | Junction above shutdown threshold |
| therm_cool | input | 1 | Junction below restart threshold |
| gate_good | input | 1 | Input-switch gate drive reached full level |
| adapter_ok | output | 1 | Adapter good indication |
| sw_en | output | 1 | Input-switch enable |
| conv_en | output | 1 | Buck converter enable |
| chg_dis | output | 1 | Charge disable |
| sysovp_stat | output | 1 | Latched system overvoltage status |

## Verification
The bench counts the retry pause to the exact tick. It checks the switch is still off one tick short of RETRY_MS and on at RETRY_MS, so an off-by-one counter or a timer that does not restart when overcurrent asserts again is caught. It drives the overvoltage trip and the clear strobe in the same cycle; a design that favours the clear would report the latch empty. It also lets the retry pause end while the latch is set; a design that released the switch there would turn it on into a fault. The thermal sequence passes through the state with neither flag set, which a design without hysteresis would turn back on. The gate deadline is checked one tick early and on time, with gate good and with it missing.

// File: rtl/pps_pkg.sv
// Shared types for the power-path protection sequencer.
package pps_pkg;

    // Hold reasons that each keep the power path off.
    typedef struct packed {
        logic ocp_wait;    // input overcurrent retry pause running
        logic ovp_latch;   // system overvoltage latched
        logic gate_fault;  // input switch failed its gate deadline
        logic therm_off;   // junction thermal hold
    } pps_hold_t;

endpackage

// File: rtl/pps_retry_timer.sv
// Auto-retry hold: asserts while a trigger is seen and releases after
// RETRY_TICKS tick pulses without the trigger. A renewed trigger restarts
// the count. Assumes tick is a single-cycle pulse.
module pps_retry_timer #(
    parameter int RETRY_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig,
    output logic hold
);
    localparam int CW = $clog2(RETRY_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(RETRY_TICKS - 1);

    logic [CW-1:0] cnt;

    // Hold flag and pause counter; the trigger reloads, ticks advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= 1'b0;
            cnt  <= '0;
        end else if (trig) begin
            hold <= 1'b1;
            cnt  <= '0;
        end else if (hold && tick) begin
            if (cnt == LAST) begin
                hold <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pps_ovp_latch.sv
// Sticky fault latch. It is set by a trip flag and cleared either by a
// host strobe or by a rising edge of adapter detect (a replug). The trip
// wins over both clears. The edge detector register runs during reset as
// well, so it always holds the previous cycle's detect level.
module pps_ovp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr_wr,
    input  logic det,
    output logic latched
);
    logic det_q;
    logic replug;

    // Previous-cycle adapter detect level for edge detection.
    always_ff @(posedge clk) begin
        det_q <= det;
    end

    // Replug is a low-to-high change of adapter detect.
    always_comb begin
        replug = det & ~det_q;
    end

    // Latch with set priority over both clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latched <= 1'b0;
        else if (trip)
            latched <= 1'b1;
        else if (clr_wr || replug)
            latched <= 1'b0;
    end
endmodule

// File: rtl/pps_gate_watch.sv
// Gate-drive deadline monitor. It counts tick pulses while the switch is
// enabled. On the DEADLINE_TICKS-th pulse it samples gate_good, and a
// false value raises a fault. The fault stays until adapter detect drops.
// Once past the deadline the counter stops and nothing is checked again.
module pps_gate_watch #(
    parameter int DEADLINE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sw_on,
    input  logic gate_good,
    input  logic det,
    output logic fault
);
    localparam int CW = $clog2(DEADLINE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEADLINE_TICKS - 1);
    localparam logic [CW-1:0] DONE = CW'(DEADLINE_TICKS);

    logic [CW-1:0] cnt;

    // On-time counter: restarts whenever the switch is off, stops at DONE.
    always_ff @(posedge clk) begin
        if (!rst_n || !sw_on)
            cnt <= '0;
        else if (tick && cnt != DONE)
            cnt <= cnt + 1'b1;
    end

    // Fault flag: cleared by adapter removal, set on a missed deadline.
    always_ff @(posedge clk) begin
        if (!rst_n || !det)
            fault <= 1'b0;
        else if (sw_on && tick && cnt == LAST && !gate_good)
            fault <= 1'b1;
    end
endmodule

// File: rtl/pps_therm_hyst.sv
// Two-threshold thermal hold. The hot flag sets the hold. Only the cool
// flag, seen without the hot flag, releases it.
module pps_therm_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    output logic off
);
    // Hysteresis state: hot sets, cool clears, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off <= 1'b0;
        else if (hot)
            off <= 1'b1;
        else if (cool)
            off <= 1'b0;
    end
endmodule

// File: rtl/pwrpath_prot_seq.sv
// Power-path protection sequencer top. It registers the adapter-good
// decision, combines the hold reasons from the retry timer, the overvoltage
// latch, the gate watch and the thermal hysteresis, and drives the switch,
// converter and charge controls. Assumes every input is already
// synchronous to clk and that ms_tick is one cycle wide.
module pwrpath_prot_seq #(
    parameter int RETRY_MS = 300,
    parameter int GATE_MS  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic vcc_ok,
    input  logic adp_det,
    input  logic awake,
    input  logic acovp,
    input  logic in_ocp,
    input  logic ocp_en,
    input  logic sys_ovp,
    input  logic ovp_clr,
    input  logic therm_hot,
    input  logic therm_cool,
    input  logic gate_good,
    output logic adapter_ok,
    output logic sw_en,
    output logic conv_en,
    output logic chg_dis,
    output logic sysovp_stat
);
    import pps_pkg::*;

    pps_hold_t hold;
    logic      aok_q;
    logic      ocp_trig;

    // Adapter-good register: supply window, detect and not sleeping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aok_q <= 1'b0;
        else
            aok_q <= vcc_ok & adp_det & awake & ~acovp;
    end

    // Overcurrent is acted on only when enabled by configuration.
    always_comb begin
        ocp_trig = ocp_en & in_ocp;
    end

    pps_retry_timer #(.RETRY_TICKS(RETRY_MS)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .trig  (ocp_trig),
        .hold  (hold.ocp_wait)
    );

    pps_ovp_latch u_ovp (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (sys_ovp),
        .clr_wr  (ovp_clr),
        .det     (adp_det),
        .latched (hold.ovp_latch)
    );

    pps_gate_watch #(.DEADLINE_TICKS(GATE_MS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ms_tick),
        .sw_on     (sw_en),
        .gate_good (gate_good),
        .det       (adp_det),
        .fault     (hold.gate_fault)
    );

    pps_therm_hyst u_therm (
        .clk   (clk),
        .rst_n (rst_n),
        .hot   (therm_hot),
        .cool  (therm_cool),
        .off   (hold.therm_off)
    );

    // Output combine: every release condition must hold at once.
    always_comb begin
        adapter_ok  = aok_q;
        sw_en       = aok_q & ~hold.ocp_wait & ~hold.ovp_latch & ~hold.gate_fault;
        conv_en     = sw_en & ~hold.therm_off;
        chg_dis     = ~conv_en;
        sysovp_stat = hold.ovp_latch;
    end
endmodule

// File: rtl/pps_checker.sv
// Temporal checks on the sequencer ports, bound to every instance.
module pps_checker (
    input logic clk,
    input logic rst_n,
    input logic ocp_en,
    input logic in_ocp,
    input logic sys_ovp,
    input logic ovp_clr,
    input logic acovp,
    input logic therm_hot,
    input logic adp_det,
    input logic adapter_ok,
    input logic sw_en,
    input logic conv_en,
    input logic chg_dis,
    input logic sysovp_stat
);
    // R2: the switch never conducts without a good adapter.
    p_sw_needs_aok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> adapter_ok);

    // R3: adapter overvoltage drops the adapter-good flag at the next edge.
    p_acovp_drops_aok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acovp |=> !adapter_ok);

    // R4: enabled overcurrent opens the switch at the next edge.
    p_ocp_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_en && in_ocp) |=> !sw_en);

    // R7: a system overvoltage trip latches status and opens the switch.
    p_ovp_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ovp |=> (sysovp_stat && !sw_en && !conv_en));

    // R7: the latch holds without a clear strobe or an adapter edge.
    p_ovp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sysovp_stat && !ovp_clr && $stable(adp_det)) |=> sysovp_stat);

    // R11: a hot junction stops the converter at the next edge.
    p_hot_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot |=> !conv_en);

    // R13: the converter runs only with the switch on; charge follows.
    p_conv_needs_sw_r13: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> sw_en);
    p_chg_vs_conv_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> chg_dis);
endmodule

bind pwrpath_prot_seq pps_checker u_pps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ocp_en      (ocp_en),
    .in_ocp      (in_ocp),
    .sys_ovp     (sys_ovp),
    .ovp_clr     (ovp_clr),
    .acovp       (acovp),
    .therm_hot   (therm_hot),
    .adp_det     (adp_det),
    .adapter_ok  (adapter_ok),
    .sw_en       (sw_en),
    .conv_en     (conv_en),
    .chg_dis     (chg_dis),
    .sysovp_stat (sysovp_stat)
);

// File: tb/pwrpath_prot_seq_bench.sv
module pwrpath_prot_seq_bench;
    localparam int RETRY = 300;
    localparam int GATE  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic vcc_ok = 1'b1, adp_det = 1'b1, awake = 1'b1, acovp = 1'b0;
    logic in_ocp = 1'b0, ocp_en = 1'b0, sys_ovp = 1'b0, ovp_clr = 1'b0;
    logic therm_hot = 1'b0, therm_cool = 1'b0, gate_good = 1'b1;
    logic adapter_ok, sw_en, conv_en, chg_dis, sysovp_stat;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrpath_prot_seq #(.RETRY_MS(RETRY), .GATE_MS(GATE)) u_pwrpath_prot_seq (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .vcc_ok(vcc_ok),
        .adp_det(adp_det), .awake(awake), .acovp(acovp), .in_ocp(in_ocp),
        .ocp_en(ocp_en), .sys_ovp(sys_ovp), .ovp_clr(ovp_clr),
        .therm_hot(therm_hot), .therm_cool(therm_cool), .gate_good(gate_good),
        .adapter_ok(adapter_ok), .sw_en(sw_en), .conv_en(conv_en),
        .chg_dis(chg_dis), .sysovp_stat(sysovp_stat)
    );

    // Vector: {vcc_ok, adp_det, awake, acovp, hot, cool | aok, sw, conv, chg_dis}
    localparam logic [9:0] VEC [11] = '{
        10'b111000_1110,  // R2 all good
        10'b011000_0001,  // R2 supply low
        10'b101000_0001,  // R2 no detect
        10'b110000_0001,  // R2 sleeping
        10'b111100_0001,  // R3 adapter overvoltage
        10'b111000_1110,  // R3 recovery
        10'b111010_1101,  // R11 hot
        10'b111000_1101,  // R11 between thresholds, still off
        10'b111001_1110,  // R11 cool releases
        10'b111011_1101,  // R11 hot wins
        10'b111001_1110   // R13 back on
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_run++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk("R1 aok", adapter_ok, 1'b0);
        chk("R1 sw", sw_en, 1'b0);
        chk("R1 conv", conv_en, 1'b0);
        chk("R1 chg_dis", chg_dis, 1'b1);
        chk("R1 stat", sysovp_stat, 1'b0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R11 R13
        for (int v = 0; v < 11; v++) begin
            {vcc_ok, adp_det, awake, acovp, therm_hot, therm_cool} = VEC[v][9:4];
            cyc(1);
            chk($sformatf("R2/R3/R11 vec%0d aok", v), adapter_ok, VEC[v][3]);
            chk($sformatf("R3 vec%0d sw", v), sw_en, VEC[v][2]);
            chk($sformatf("R11 vec%0d conv", v), conv_en, VEC[v][1]);
            chk($sformatf("R13 vec%0d chg_dis", v), chg_dis, VEC[v][0]);
        end
        therm_cool = 1'b0;
        cyc(1);

        // R5: overcurrent ignored when disabled
        in_ocp = 1'b1;
        cyc(2);
        chk("R5 sw during ocp", sw_en, 1'b1);
        chk("R5 chg_dis during ocp", chg_dis, 1'b0);
        in_ocp = 1'b0;
        cyc(1);
        chk("R5 sw after ocp", sw_en, 1'b1);

        // R4: trip and exact retry
        ocp_en = 1'b1;
        in_ocp = 1'b1;
        cyc(1);
        in_ocp = 1'b0;
        chk("R4 sw off", sw_en, 1'b0);
        chk("R4 chg_dis", chg_dis, 1'b1);
        ticks(RETRY - 1);
        chk("R4 one tick early", sw_en, 1'b0);
        ticks(1);
        chk("R4 released", sw_en, 1'b1);
        chk("R4 conv back", conv_en, 1'b1);

        // R6: re-trigger restarts the pause
        in_ocp = 1'b1;
        cyc(1);
        in_ocp = 1'b0;
        ticks(200);
        in_ocp = 1'b1;
        cyc(1);
        in_ocp = 1'b0;
        ticks(200);
        chk("R6 restarted", sw_en, 1'b0);
        ticks(100);
        chk("R6 released", sw_en, 1'b1);

        // R7: latch
        sys_ovp = 1'b1;
        cyc(1);
        sys_ovp = 1'b0;
        chk("R7 stat", sysovp_stat, 1'b1);
        chk("R7 sw", sw_en, 1'b0);
        chk("R7 conv", conv_en, 1'b0);
        cyc(5);
        chk("R7 held", sysovp_stat, 1'b1);

        // R10: retry expiry does not override the latch
        in_ocp = 1'b1;
        cyc(1);
        in_ocp = 1'b0;
        ticks(RETRY + 2);
        chk("R10 sw stays off", sw_en, 1'b0);

        // R8: trip wins over clear, then clear works
        sys_ovp = 1'b1;
        ovp_clr = 1'b1;
        cyc(1);
        sys_ovp = 1'b0;
        ovp_clr = 1'b0;
        chk("R8 trip wins", sysovp_stat, 1'b1);
        ovp_clr = 1'b1;
        cyc(1);
        ovp_clr = 1'b0;
        chk("R8 cleared", sysovp_stat, 1'b0);
        chk("R8 sw on", sw_en, 1'b1);

        // R9: replug clears the latch
        sys_ovp = 1'b1;
        cyc(1);
        sys_ovp = 1'b0;
        adp_det = 1'b0;
        cyc(1);
        chk("R9 still latched", sysovp_stat, 1'b1);
        adp_det = 1'b1;
        cyc(1);
        chk("R9 cleared", sysovp_stat, 1'b0);
        chk("R9 sw on", sw_en, 1'b1);

        // R12: gate deadline
        gate_good = 1'b0;
        ticks(GATE - 1);
        chk("R12 before deadline", sw_en, 1'b1);
        ticks(1);
        chk("R12 forced off", sw_en, 1'b0);
        ticks(3);
        chk("R12 stays off", sw_en, 1'b0);
        gate_good = 1'b1;
        adp_det = 1'b0;
        cyc(1);
        adp_det = 1'b1;
        cyc(1);
        chk("R12 cleared by removal", sw_en, 1'b1);
        ticks(GATE + 5);
        chk("R12 good gate stays on", sw_en, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule